// File: doc/BRIEF.md
# Local Bus Transfer Error Monitor

This block sits beside a simple memory-mapped local bus that serves four chip-select banks. It decodes each accepted request against a table of banks. Each bank has a base, a compare mask, a valid bit and a read-only bit. The block drives a one-hot bank select for the length of the transfer. It records transfer faults as sticky status bits, which are cleared by writing 1.

The faults it watches are:
- a request that hits no bank;
- a write to a read-only bank;
- a transfer that gets no data beat before the bus watchdog expires;
- an atomic reservation whose second half never arrives.

It also follows an external command sequencer. It records that sequencer's completion and runs its own timer on the sequencer's commands.

The block ORs the enabled status bits into one interrupt line. The attributes of the first bus fault are held until software clears every fault bit.

Top module: `lbus_err_mon`

## Requirements
- R1: A request is decoded against every valid bank. A bank matches when `(reqAddr ^ base) & mask` is zero. The lowest-numbered matching bank wins. `bankSel` (bit i = bank i) is one-hot from the edge after acceptance until the transfer ends.
- R2: An accepted request that matches no valid bank sets status bit 0. No bank is selected for it.
- R3: A write that hits a read-only bank sets status bit 1. The write does not raise `bankSel`, and the transfer is not ended. The bus watchdog (R4) therefore fires later unless a beat is acknowledged.
- R4: The watchdog limit is `cfgTmoCount * cfgTmoScale`. If no `ackBeat` comes within that many clock edges after the request edge, status bit 2 is set on that edge. `busAbort` then pulses for one cycle and the transfer ends. An `ackBeat` on the last edge still ends the transfer cleanly. A limit of zero disables the watchdog.
- R5: An atomic read (`reqAtomic`=1, `reqWrite`=0) to a valid bank opens a reservation. If no write to the same bank is accepted within 256 edges, status bit 3 is set on the 256th edge. A write to another bank does not close the reservation.
- R6: An atomic write to a valid bank opens a reservation. If no read of the same bank is accepted within 256 edges, status bit 4 is set.
- R7: A `seqDone` pulse sets status bit 6 only while a command started by `seqStart` is running. `seqDone` is ignored otherwise. If the command runs for `cfgSeqLimit` edges (nonzero) without `seqDone`, status bit 5 is set.
- R8: Status bits are sticky. A `clrValid` cycle clears exactly the bits where `clrBits` is 1. Bits written with 0 keep their value.
- R9: `intReq` is 1 exactly when some status bit is set with its `intEnable` bit set.
- R10: Bits 0 to 4 are the bus fault bits. A bus fault raised while none of them is set captures the bank index, direction and address into `attrBank`, `attrWrite` and `attrAddr`. The bank index is 0 for a miss. Later faults leave these outputs unchanged until bits 0 to 4 are all cleared.
- R11: A request presented while a transfer is outstanding is ignored. It raises no status bit and does not change `bankSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rstN | input | 1 | asynchronous active-low reset |
| cfgBankBase | input | NB*AW | bank base addresses, bank i at bits [i*AW +: AW] |
| cfgBankMask | input | NB*AW | bank compare masks, same packing |
| cfgBankValid | input | NB | bank enabled |
| cfgBankReadOnly | input | NB | bank rejects writes |
| cfgTmoCount | input | CNTW | watchdog count factor |
| cfgTmoScale | input | SCLW | watchdog prescale factor |
| cfgSeqLimit | input | SEQW | sequencer command time limit, 0 = off |
| reqValid | input | 1 | request strobe |
| reqAddr | input | AW | request address |
| reqWrite | input | 1 | 1 = write |
| reqAtomic | input | 1 | request carries a reservation |
| ackBeat | input | 1 | data beat acknowledged, ends the transfer |
| bankSel | output | NB | one-hot bank select |
| busAbort | output | 1 | one-cycle pulse when the watchdog ends a transfer |
| seqStart | input | 1 | sequencer command started |
| seqDone | input | 1 | sequencer command finished |
| clrValid | input | 1 | status clear strobe |
| clrBits | input | 7 | write-1-to-clear mask |
| intEnable | input | 7 | per-bit interrupt enable |
| statusFlags | output | 7 | sticky status bits |
| intReq | output | 1 | interrupt |
| attrBank | output | BW | captured bank index |
| attrWrite | output | 1 | captured direction |
| attrAddr | output | AW | captured address |

## Verification
The bank table is configured so that two banks overlap, one bank is read-only and one bank is disabled. Addresses are chosen to separate lowest-index priority from plain matching, and a disabled bank from an enabled one. Watchdog and reservation windows are probed one edge before and exactly at their limit, so an off-by-one count is caught. The closing request of a reservation is sent to the wrong bank as well as to the right one. Clear masks with zero bits, interrupt enables that do or do not cover the set bit, and a second fault after the first one separate the sticky, masking and capture-hold behaviours.

// File: rtl/lbus_err_pkg.sv
package lbus_err_pkg;
  localparam int FLAG_N = 7;
  localparam int ERR_N = 5;
  localparam int FL_CS_MISS = 0;
  localparam int FL_WR_PROT = 1;
  localparam int FL_BUS_TMO = 2;
  localparam int FL_ATOM_WR = 3;
  localparam int FL_ATOM_RD = 4;
  localparam int FL_CMD_TMO = 5;
  localparam int FL_CMD_DONE = 6;

  typedef struct packed {
    logic [FLAG_N-1:0] setFlags;
    logic              busFault;
  } dp_strobe_t;
endpackage

// File: rtl/lbus_bank_dec.sv
module lbus_bank_dec #(
  parameter int NB = 4,
  parameter int AW = 32,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [AW-1:0]    addr,
  input  logic [NB*AW-1:0] baseFlat,
  input  logic [NB*AW-1:0] maskFlat,
  input  logic [NB-1:0]    valid,
  output logic             hit,
  output logic [BW-1:0]    hitIdx
);
  logic [NB-1:0] matchVec;

  for (genvar gi = 0; gi < NB; gi++) begin : g_cmp
    assign matchVec[gi] = valid[gi] &&
      (((addr ^ baseFlat[gi*AW +: AW]) & maskFlat[gi*AW +: AW]) == '0);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = BW'(i);
    end
  end

  assign hit = |matchVec;
endmodule

// File: rtl/lbus_err_ctrl.sv
module lbus_err_ctrl
  import lbus_err_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 32,
  parameter int CNTW = 8,
  parameter int SCLW = 4,
  parameter int SEQW = 16,
  parameter int ATOM_WIN = 256,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int TW = CNTW + SCLW,
  localparam int WINW = $clog2(ATOM_WIN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NB*AW-1:0] cfgBankBase,
  input  logic [NB*AW-1:0] cfgBankMask,
  input  logic [NB-1:0]    cfgBankValid,
  input  logic [NB-1:0]    cfgBankReadOnly,
  input  logic [CNTW-1:0]  cfgTmoCount,
  input  logic [SCLW-1:0]  cfgTmoScale,
  input  logic [SEQW-1:0]  cfgSeqLimit,
  input  logic             reqValid,
  input  logic [AW-1:0]    reqAddr,
  input  logic             reqWrite,
  input  logic             reqAtomic,
  input  logic             ackBeat,
  input  logic             seqStart,
  input  logic             seqDone,
  output logic [NB-1:0]    bankSel,
  output logic             busAbort,
  output dp_strobe_t       strobe,
  output logic [BW-1:0]    capBank,
  output logic             capWrite,
  output logic [AW-1:0]    capAddr
);
  logic          hit;
  logic [BW-1:0] hitIdx;

  lbus_bank_dec #(.NB(NB), .AW(AW)) u_dec (
    .addr(reqAddr), .baseFlat(cfgBankBase), .maskFlat(cfgBankMask),
    .valid(cfgBankValid), .hit(hit), .hitIdx(hitIdx)
  );

  // transfer tracking and watchdog
  logic          busActive;
  logic [TW-1:0] busCnt;
  logic [TW-1:0] tmoLimit;
  logic [NB-1:0] bankSelQ;
  logic [BW-1:0] curBank;
  logic          curWrite;
  logic [AW-1:0] curAddr;
  logic          busAbortQ;
  logic          accept, csMiss, roViol, tmoFire;

  assign tmoLimit = TW'(cfgTmoCount) * TW'(cfgTmoScale);
  assign accept   = reqValid && !busActive;
  assign csMiss   = accept && !hit;
  assign roViol   = accept && hit && reqWrite && cfgBankReadOnly[hitIdx];
  assign tmoFire  = busActive && !ackBeat && (tmoLimit != '0) &&
                    (busCnt == tmoLimit - TW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busActive <= 1'b0;
      busCnt    <= '0;
      bankSelQ  <= '0;
      curBank   <= '0;
      curWrite  <= 1'b0;
      curAddr   <= '0;
      busAbortQ <= 1'b0;
    end else begin
      busAbortQ <= tmoFire;
      if (accept) begin
        busActive <= 1'b1;
        busCnt    <= '0;
        bankSelQ  <= (hit && !roViol) ? (NB'(1) << hitIdx) : '0;
        curBank   <= hit ? hitIdx : '0;
        curWrite  <= reqWrite;
        curAddr   <= reqAddr;
      end else if (busActive) begin
        if (ackBeat || tmoFire) begin
          busActive <= 1'b0;
          bankSelQ  <= '0;
        end else begin
          busCnt <= busCnt + TW'(1);
        end
      end
    end
  end

  // atomic reservation window
  logic            rsvArmed;
  logic            rsvWrite;
  logic [BW-1:0]   rsvBank;
  logic [AW-1:0]   rsvAddr;
  logic [WINW-1:0] rsvCnt;
  logic            rsvMatch, rsvExpire;

  assign rsvMatch  = accept && hit && rsvArmed && (hitIdx == rsvBank) &&
                     (reqWrite != rsvWrite);
  assign rsvExpire = rsvArmed && !rsvMatch && (rsvCnt == WINW'(ATOM_WIN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsvArmed <= 1'b0;
      rsvWrite <= 1'b0;
      rsvBank  <= '0;
      rsvAddr  <= '0;
      rsvCnt   <= '0;
    end else if (accept && hit && reqAtomic && !rsvMatch) begin
      rsvArmed <= 1'b1;
      rsvWrite <= reqWrite;
      rsvBank  <= hitIdx;
      rsvAddr  <= reqAddr;
      rsvCnt   <= '0;
    end else if (rsvMatch || rsvExpire) begin
      rsvArmed <= 1'b0;
    end else if (rsvArmed) begin
      rsvCnt <= rsvCnt + WINW'(1);
    end
  end

  // external command sequencer follow-up
  logic            seqArmed;
  logic [SEQW-1:0] seqCnt;
  logic            seqDoneEv, seqTmoEv;

  assign seqDoneEv = seqArmed && seqDone;
  assign seqTmoEv  = seqArmed && !seqDone && (cfgSeqLimit != '0) &&
                     (seqCnt == cfgSeqLimit - SEQW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqArmed <= 1'b0;
      seqCnt   <= '0;
    end else if (seqStart) begin
      seqArmed <= 1'b1;
      seqCnt   <= '0;
    end else if (seqDoneEv || seqTmoEv) begin
      seqArmed <= 1'b0;
    end else if (seqArmed) begin
      seqCnt <= seqCnt + SEQW'(1);
    end
  end

  // strobes and attribute candidates
  always_comb begin
    strobe = '0;
    strobe.setFlags[FL_CS_MISS]  = csMiss;
    strobe.setFlags[FL_WR_PROT]  = roViol;
    strobe.setFlags[FL_BUS_TMO]  = tmoFire;
    strobe.setFlags[FL_ATOM_WR]  = rsvExpire && !rsvWrite;
    strobe.setFlags[FL_ATOM_RD]  = rsvExpire && rsvWrite;
    strobe.setFlags[FL_CMD_TMO]  = seqTmoEv;
    strobe.setFlags[FL_CMD_DONE] = seqDoneEv;
    strobe.busFault = csMiss || roViol || tmoFire || rsvExpire;
  end

  always_comb begin
    if (csMiss || roViol) begin
      capBank  = hit ? hitIdx : '0;
      capWrite = reqWrite;
      capAddr  = reqAddr;
    end else if (tmoFire) begin
      capBank  = curBank;
      capWrite = curWrite;
      capAddr  = curAddr;
    end else begin
      capBank  = rsvBank;
      capWrite = rsvWrite;
      capAddr  = rsvAddr;
    end
  end

  assign bankSel  = bankSelQ;
  assign busAbort = busAbortQ;

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankSelQ));
  p_wp_no_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    roViol |=> (bankSelQ == '0) && busActive);
  p_ack_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    busActive && ackBeat |=> !busActive && !busAbortQ);
  p_abort_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    busAbortQ |=> !busAbortQ);
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    busActive && !ackBeat && !tmoFire |=> $stable(curAddr) && $stable(bankSelQ));
endmodule

// File: rtl/lbus_err_dp.sv
module lbus_err_dp
  import lbus_err_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 32,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [BW-1:0]     capBank,
  input  logic              capWrite,
  input  logic [AW-1:0]     capAddr,
  input  logic              clrValid,
  input  logic [FLAG_N-1:0] clrBits,
  input  logic [FLAG_N-1:0] intEnable,
  output logic [FLAG_N-1:0] statusFlags,
  output logic              intReq,
  output logic [BW-1:0]     attrBank,
  output logic              attrWrite,
  output logic [AW-1:0]     attrAddr
);
  logic [FLAG_N-1:0] flagsQ;
  logic [FLAG_N-1:0] clrMask;
  logic              errPend;
  logic [BW-1:0]     attrBankQ;
  logic              attrWriteQ;
  logic [AW-1:0]     attrAddrQ;

  assign clrMask = clrValid ? clrBits : '0;
  assign errPend = |flagsQ[ERR_N-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else begin
      flagsQ <= (flagsQ & ~clrMask) | strobe.setFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrBankQ  <= '0;
      attrWriteQ <= 1'b0;
      attrAddrQ  <= '0;
    end else if (strobe.busFault && !errPend) begin
      attrBankQ  <= capBank;
      attrWriteQ <= capWrite;
      attrAddrQ  <= capAddr;
    end
  end

  assign statusFlags = flagsQ;
  assign intReq      = |(flagsQ & intEnable);
  assign attrBank    = attrBankQ;
  assign attrWrite   = attrWriteQ;
  assign attrAddr    = attrAddrQ;

  p_set_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.setFlags) |=> ((flagsQ & $past(strobe.setFlags)) == $past(strobe.setFlags)));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagsQ & ~clrMask)) |=> ((flagsQ & $past(flagsQ & ~clrMask)) == $past(flagsQ & ~clrMask)));
  p_int_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (|flagsQ));
  p_attr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    errPend |=> $stable({attrBankQ, attrWriteQ, attrAddrQ}));
endmodule

// File: rtl/lbus_err_mon.sv
module lbus_err_mon
  import lbus_err_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 32,
  parameter int CNTW = 8,
  parameter int SCLW = 4,
  parameter int SEQW = 16,
  parameter int ATOM_WIN = 256,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NB*AW-1:0]  cfgBankBase,
  input  logic [NB*AW-1:0]  cfgBankMask,
  input  logic [NB-1:0]     cfgBankValid,
  input  logic [NB-1:0]     cfgBankReadOnly,
  input  logic [CNTW-1:0]   cfgTmoCount,
  input  logic [SCLW-1:0]   cfgTmoScale,
  input  logic [SEQW-1:0]   cfgSeqLimit,
  input  logic              reqValid,
  input  logic [AW-1:0]     reqAddr,
  input  logic              reqWrite,
  input  logic              reqAtomic,
  input  logic              ackBeat,
  output logic [NB-1:0]     bankSel,
  output logic              busAbort,
  input  logic              seqStart,
  input  logic              seqDone,
  input  logic              clrValid,
  input  logic [FLAG_N-1:0] clrBits,
  input  logic [FLAG_N-1:0] intEnable,
  output logic [FLAG_N-1:0] statusFlags,
  output logic              intReq,
  output logic [BW-1:0]     attrBank,
  output logic              attrWrite,
  output logic [AW-1:0]     attrAddr
);
  dp_strobe_t    strobe;
  logic [BW-1:0] capBank;
  logic          capWrite;
  logic [AW-1:0] capAddr;

  lbus_err_ctrl #(.NB(NB), .AW(AW), .CNTW(CNTW), .SCLW(SCLW), .SEQW(SEQW),
                  .ATOM_WIN(ATOM_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgBankBase(cfgBankBase), .cfgBankMask(cfgBankMask),
    .cfgBankValid(cfgBankValid), .cfgBankReadOnly(cfgBankReadOnly),
    .cfgTmoCount(cfgTmoCount), .cfgTmoScale(cfgTmoScale), .cfgSeqLimit(cfgSeqLimit),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqAtomic(reqAtomic),
    .ackBeat(ackBeat), .seqStart(seqStart), .seqDone(seqDone),
    .bankSel(bankSel), .busAbort(busAbort), .strobe(strobe),
    .capBank(capBank), .capWrite(capWrite), .capAddr(capAddr)
  );

  lbus_err_dp #(.NB(NB), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .capBank(capBank), .capWrite(capWrite), .capAddr(capAddr),
    .clrValid(clrValid), .clrBits(clrBits), .intEnable(intEnable),
    .statusFlags(statusFlags), .intReq(intReq),
    .attrBank(attrBank), .attrWrite(attrWrite), .attrAddr(attrAddr)
  );
endmodule

// File: tb/tb_lbus_err_mon.sv
module tb_lbus_err_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB*AW-1:0] cfgBankBase, cfgBankMask;
  logic [NB-1:0] cfgBankValid, cfgBankReadOnly;
  logic [7:0] cfgTmoCount;
  logic [3:0] cfgTmoScale;
  logic [15:0] cfgSeqLimit;
  logic reqValid = 0, reqWrite = 0, reqAtomic = 0, ackBeat = 0;
  logic [AW-1:0] reqAddr = '0;
  logic seqStart = 0, seqDone = 0, clrValid = 0;
  logic [6:0] clrBits = '0, intEnable = '0;
  logic [NB-1:0] bankSel;
  logic busAbort, intReq, attrWrite;
  logic [6:0] statusFlags;
  logic [1:0] attrBank;
  logic [AW-1:0] attrAddr;

  int checks = 0;
  int failures = 0;

  lbus_err_mon dut (
    .clk(clk), .rstN(rstN), .cfgBankBase(cfgBankBase), .cfgBankMask(cfgBankMask),
    .cfgBankValid(cfgBankValid), .cfgBankReadOnly(cfgBankReadOnly),
    .cfgTmoCount(cfgTmoCount), .cfgTmoScale(cfgTmoScale), .cfgSeqLimit(cfgSeqLimit),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqAtomic(reqAtomic),
    .ackBeat(ackBeat), .bankSel(bankSel), .busAbort(busAbort),
    .seqStart(seqStart), .seqDone(seqDone), .clrValid(clrValid), .clrBits(clrBits),
    .intEnable(intEnable), .statusFlags(statusFlags), .intReq(intReq),
    .attrBank(attrBank), .attrWrite(attrWrite), .attrAddr(attrAddr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic doReq(input logic [AW-1:0] a, input logic w, input logic at);
    reqValid = 1; reqAddr = a; reqWrite = w; reqAtomic = at;
    idle(1);
    reqValid = 0; reqAtomic = 0;
  endtask

  task automatic ackNow();
    ackBeat = 1;
    idle(1);
    ackBeat = 0;
  endtask

  task automatic clearAll();
    clrValid = 1; clrBits = '1;
    idle(1);
    clrValid = 0; clrBits = '0;
  endtask

  task automatic testReset();
    chk("R8 reset status", 64'(statusFlags), 0);
    chk("R1 reset bankSel", 64'(bankSel), 0);
    chk("R9 reset intReq", 64'(intReq), 0);
  endtask

  task automatic testDecode();
    doReq(32'h0000_1234, 0, 0);
    chk("R1 overlap picks bank0", 64'(bankSel), 64'h1);
    idle(3);
    chk("R1 select held", 64'(bankSel), 64'h1);
    ackNow();
    chk("R1 select drops on ack", 64'(bankSel), 0);
    doReq(32'h0000_5000, 1, 0);
    chk("R1 bank1 only", 64'(bankSel), 64'h2);
    ackNow();
    chk("R1 no faults", 64'(statusFlags), 0);
  endtask

  task automatic testMissDisabled();
    doReq(32'h3000_0040, 0, 0);
    chk("R2 disabled bank misses", 64'(statusFlags[0]), 1);
    chk("R2 no select", 64'(bankSel), 0);
    chk("R10 miss attr addr", 64'(attrAddr), 64'h3000_0040);
    chk("R10 miss attr bank", 64'(attrBank), 0);
    chk("R10 miss attr dir", 64'(attrWrite), 0);
    ackNow();
    clearAll();
  endtask

  task automatic testWriteProtect();
    doReq(32'h2000_0010, 1, 0);
    chk("R3 wp flag", 64'(statusFlags[1]), 1);
    chk("R3 wp no select", 64'(bankSel), 0);
    idle(9);
    chk("R3 not yet timed out", 64'(statusFlags[2]), 0);
    idle(1);
    chk("R3 wp leads to timeout", 64'(statusFlags[2]), 1);
    chk("R4 abort pulse", 64'(busAbort), 1);
    chk("R10 attr bank kept", 64'(attrBank), 2);
    chk("R10 attr dir kept", 64'(attrWrite), 1);
    chk("R10 attr addr kept", 64'(attrAddr), 64'h2000_0010);
    idle(1);
    chk("R4 abort one cycle", 64'(busAbort), 0);
    clearAll();
    doReq(32'h4000_0000, 0, 0);
    chk("R10 recapture after clear", 64'(attrAddr), 64'h4000_0000);
    chk("R10 recapture dir", 64'(attrWrite), 0);
    ackNow();
    clearAll();
  endtask

  task automatic testTimeout();
    doReq(32'h0000_1000, 0, 0);
    idle(9);
    chk("R4 edge before limit", 64'(statusFlags[2]), 0);
    idle(1);
    chk("R4 timeout at limit", 64'(statusFlags[2]), 1);
    chk("R4 select released", 64'(bankSel), 0);
    clearAll();
    doReq(32'h0000_1000, 0, 0);
    idle(9);
    ackNow();
    chk("R4 ack on last edge", 64'(statusFlags[2]), 0);
    chk("R4 no abort", 64'(busAbort), 0);
    cfgTmoCount = 0;
    doReq(32'h0000_1000, 0, 0);
    idle(40);
    chk("R4 zero limit disables", 64'(statusFlags[2]), 0);
    ackNow();
    cfgTmoCount = 8'd5;
  endtask

  task automatic testBusyIgnore();
    doReq(32'h0000_1000, 0, 0);
    doReq(32'h4000_0000, 1, 0);
    chk("R11 busy request no miss", 64'(statusFlags), 0);
    chk("R11 select unchanged", 64'(bankSel), 64'h1);
    ackNow();
  endtask

  task automatic testAtomic();
    doReq(32'h0000_1010, 0, 1);
    ackNow();
    idle(254);
    chk("R5 window not yet over", 64'(statusFlags[3]), 0);
    idle(1);
    chk("R5 atomic write missing", 64'(statusFlags[3]), 1);
    chk("R10 atomic attr addr", 64'(attrAddr), 64'h0000_1010);
    clearAll();
    doReq(32'h0000_1010, 0, 1);
    ackNow();
    doReq(32'h0000_5000, 1, 0);
    ackNow();
    idle(300);
    chk("R5 other bank does not close", 64'(statusFlags[3]), 1);
    clearAll();
    doReq(32'h0000_1010, 0, 1);
    ackNow();
    doReq(32'h0000_1100, 1, 0);
    ackNow();
    idle(300);
    chk("R5 matching write closes", 64'(statusFlags[3]), 0);
    doReq(32'h0000_5000, 1, 1);
    ackNow();
    idle(300);
    chk("R6 atomic read missing", 64'(statusFlags[4]), 1);
    chk("R6 not the write flag", 64'(statusFlags[3]), 0);
    clearAll();
  endtask

  task automatic testSequencer();
    seqDone = 1; idle(1); seqDone = 0;
    chk("R7 stray done ignored", 64'(statusFlags[6]), 0);
    seqStart = 1; idle(1); seqStart = 0;
    idle(4);
    seqDone = 1; idle(1); seqDone = 0;
    chk("R7 done flag", 64'(statusFlags[6]), 1);
    chk("R7 no cmd timeout", 64'(statusFlags[5]), 0);
    clearAll();
    seqStart = 1; idle(1); seqStart = 0;
    idle(25);
    chk("R7 cmd timeout", 64'(statusFlags[5]), 1);
    chk("R7 timeout not done", 64'(statusFlags[6]), 0);
    clearAll();
  endtask

  task automatic testClearAndInt();
    doReq(32'h4000_0000, 0, 0);
    ackNow();
    clrValid = 1; clrBits = 7'h00; idle(1);
    chk("R8 zero write keeps", 64'(statusFlags[0]), 1);
    clrBits = 7'h02; idle(1);
    chk("R8 other bit keeps", 64'(statusFlags[0]), 1);
    clrValid = 0; clrBits = '0;
    chk("R9 disabled no int", 64'(intReq), 0);
    intEnable = 7'h04;
    #1;
    chk("R9 other enable no int", 64'(intReq), 0);
    intEnable = 7'h01;
    #1;
    chk("R9 enabled int", 64'(intReq), 1);
    clrValid = 1; clrBits = 7'h01; idle(1);
    clrValid = 0; clrBits = '0;
    chk("R8 w1c clears", 64'(statusFlags[0]), 0);
    chk("R9 int drops", 64'(intReq), 0);
    intEnable = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfgBankBase = {32'h3000_0000, 32'h2000_0000, 32'h0000_0000, 32'h0000_1000};
    cfgBankMask = {32'hF000_0000, 32'hF000_0000, 32'hFFFF_0000, 32'hFFFF_F000};
    cfgBankValid = 4'b0111;
    cfgBankReadOnly = 4'b0100;
    cfgTmoCount = 8'd5;
    cfgTmoScale = 4'd2;
    cfgSeqLimit = 16'd20;
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testDecode();
    testMissDisabled();
    testWriteProtect();
    testTimeout();
    testBusyIgnore();
    testAtomic();
    testSequencer();
    testClearAndInt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule